// File: doc/BRIEF.md
# Guest Address Translation Walker

This block turns a 32-bit guest-side address into a machine address for whichever guest currently owns the core. It first looks up a small fully associative cache of page mappings. On a miss it walks a two-level table in memory. The walk starts from a base register and goes through a narrow read port that has one read outstanding at a time. A table word is usable only when its bit 0 is set. If either level yields an unusable word, the request ends with a fault flag and a zero address.

Requests use a ready/valid handshake and are served one at a time. Each answer is a single-cycle pulse that carries the fault flag and the translated address. Software loads a new base register value on every guest switch, and that load empties the cache. A separate flush input empties the cache without changing the base.

Top module: `ipa_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the cache holds nothing, so the first translation always walks the tables.
- R2: The first-level read address is `{base[31:12], 12'h000} + 4*addr[31:22]`.
- R3: A usable first-level word W selects the second-level read address `{W[31:12], 12'h000} + 4*addr[21:12]`.
- R4: A usable second-level word P gives the result `{P[31:12], addr[11:0]}` with `rsp_fault` = 0.
- R5: A table word with bit 0 clear is unusable. An unusable first-level word ends the request with `rsp_fault` = 1 and `rsp_addr` = 0, and no second-level read is made.
- R6: An unusable second-level word ends the request with a fault, and nothing is cached, so the same page walks again on its next request.
- R7: A cache hit answers in the cycle after acceptance and makes no memory read.
- R8: A successful walk caches its page mapping in the lowest-numbered empty entry. When all 4 entries are full, it replaces the entry at a round-robin pointer, which starts at 0 and advances by one (wrapping) on each such replacement.
- R9: A write to the base register empties every cache entry, and later walks use the new base.
- R10: A pulse on `flush` empties every cache entry.
- R11: A flush or base write that lands while a walk is under way does not change that walk's answer, but the walk's mapping is not cached.
- R12: `req_ready` is low from acceptance until the cycle after the response pulse. `rsp_valid` and `mem_req_valid` are single-cycle pulses, and a new memory read is issued only after the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | Guest-side address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Result is a translation fault |
| rsp_addr | output | 32 | Translated address, 0 on fault |
| base_we | input | 1 | Load base register and flush cache |
| base_wdata | input | 32 | New base; bits 31:12 kept |
| flush | input | 1 | Empty the translation cache |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table read data present |
| mem_rsp_data | input | 32 | Table word read back |

## Verification
Suppose a request is accepted at a clock edge and memory returns data D cycles after the read-request cycle. Then a hit answers one cycle later. A first-level fault answers after 2+D cycles and a complete walk after 3+2D cycles. The first table read is due one cycle after acceptance and the second read 2+D cycles after acceptance. The bench's memory has D = 2, so those latencies are 1, 4 and 7 cycles, with reads at cycles 1 and 4. The reference model counts the cycles since acceptance and compares ready, the response pulse, its data, and every memory read request on the falling edge of each clock, so each result is checked in exactly the cycle it is due.

// File: rtl/ipa_xlate_pkg.sv
package ipa_xlate_pkg;

    // Walker sequencing: one table level per request/wait pair
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_RESP
    } walk_st_e;

endpackage

// File: rtl/ipa_xlate_cache.sv
module ipa_xlate_cache #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic             flush
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [PTR_W-1:0]              ptr;
    } cache_t;

    cache_t s_d, s_q;

    logic [ENTRIES-1:0] match;
    logic               has_free;
    logic [PTR_W-1:0]   free_idx;

    // Per-entry tag compare
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = s_q.vld[g] && (s_q.vpn[g] == lk_vpn);
    end

    assign lk_hit = |match;

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_ppn = lk_ppn | s_q.ppn[i];
        end
    end

    // Lowest-numbered empty slot
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!s_q.vld[i]) begin
                has_free = 1'b1;
                free_idx = PTR_W'(i);
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.vld = '0;
        end else if (ins_en) begin
            if (has_free) begin
                s_d.vld[free_idx] = 1'b1;
                s_d.vpn[free_idx] = ins_vpn;
                s_d.ppn[free_idx] = ins_ppn;
            end else begin
                s_d.vpn[s_q.ptr] = ins_vpn;
                s_d.ppn[s_q.ptr] = ins_ppn;
                s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ipa_xlate_walker.sv
module ipa_xlate_walker
    import ipa_xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int L1_W  = 10,
    parameter int L2_W  = 10,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_addr,
    output logic                  req_ready,
    input  logic                  lk_hit,
    input  logic [VA_W-OFF_W-1:0] lk_ppn,
    input  logic [VA_W-OFF_W-1:0] base_pn,
    input  logic                  kill,
    output logic                  mem_req_valid,
    output logic [VA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [VA_W-1:0]       mem_rsp_data,
    output logic                  ins_en,
    output logic [VA_W-OFF_W-1:0] ins_vpn,
    output logic [VA_W-OFF_W-1:0] ins_ppn,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic [VA_W-1:0]       rsp_addr
);
    localparam int PN_W   = VA_W - OFF_W;
    localparam int L1_LSB = VA_W - L1_W;
    localparam int L2_LSB = OFF_W;

    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic [PN_W-1:0] tbl_pn;
        logic [VA_W-1:0] res;
        logic            fault;
        logic            stale;
    } wk_t;

    wk_t s_d, s_q;

    logic [L1_W-1:0]  idx1;
    logic [L2_W-1:0]  idx2;
    logic [OFF_W-1:0] off;
    logic [PN_W-1:0]  rsp_pn;
    logic             word_ok;

    assign idx1    = s_q.va[L1_LSB +: L1_W];
    assign idx2    = s_q.va[L2_LSB +: L2_W];
    assign off     = s_q.va[OFF_W-1:0];
    assign rsp_pn  = mem_rsp_data[VA_W-1:OFF_W];
    assign word_ok = mem_rsp_data[0];

    always_comb begin
        s_d           = s_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        ins_en        = 1'b0;
        ins_vpn       = s_q.va[VA_W-1:OFF_W];
        ins_ppn       = rsp_pn;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.va    = req_addr;
                    s_d.stale = 1'b0;
                    if (lk_hit) begin
                        s_d.res   = {lk_ppn, req_addr[OFF_W-1:0]};
                        s_d.fault = 1'b0;
                        s_d.st    = ST_RESP;
                    end else begin
                        s_d.st = ST_L1_REQ;
                    end
                end
            end
            ST_L1_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {base_pn, {OFF_W{1'b0}}} + VA_W'({idx1, 2'b00});
                s_d.st        = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (word_ok) begin
                        s_d.tbl_pn = rsp_pn;
                        s_d.st     = ST_L2_REQ;
                    end else begin
                        s_d.res   = '0;
                        s_d.fault = 1'b1;
                        s_d.st    = ST_RESP;
                    end
                end
            end
            ST_L2_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {s_q.tbl_pn, {OFF_W{1'b0}}} + VA_W'({idx2, 2'b00});
                s_d.st        = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.st = ST_RESP;
                    if (word_ok) begin
                        s_d.res   = {rsp_pn, off};
                        s_d.fault = 1'b0;
                        ins_en    = !s_q.stale;
                    end else begin
                        s_d.res   = '0;
                        s_d.fault = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
        // A flush seen mid-walk keeps this walk's mapping out of the cache
        if (kill && (s_q.st != ST_IDLE)) s_d.stale = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign rsp_valid = (s_q.st == ST_RESP);
    assign rsp_fault = s_q.fault;
    assign rsp_addr  = s_q.res;

endmodule

// File: rtl/ipa_xlate.sv
module ipa_xlate #(
    parameter int VA_W    = 32,
    parameter int L1_W    = 10,
    parameter int L2_W    = 10,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_addr,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [VA_W-1:0] rsp_addr,
    input  logic            base_we,
    input  logic [VA_W-1:0] base_wdata,
    input  logic            flush,
    output logic            mem_req_valid,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data
);
    localparam int PN_W = VA_W - OFF_W;

    typedef struct packed {
        logic [PN_W-1:0] base_pn;
    } top_t;

    top_t s_d, s_q;

    logic            kill;
    logic            lk_hit;
    logic [PN_W-1:0] lk_ppn;
    logic            ins_en;
    logic [PN_W-1:0] ins_vpn;
    logic [PN_W-1:0] ins_ppn;
    logic            unused_bits;

    assign kill        = flush | base_we;
    assign unused_bits = ^{base_wdata[OFF_W-1:0], mem_rsp_data[OFF_W-1:1]};

    always_comb begin
        s_d = s_q;
        if (base_we) s_d.base_pn = base_wdata[VA_W-1:OFF_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ipa_xlate_cache #(
        .ENTRIES (ENTRIES),
        .VPN_W   (PN_W),
        .PPN_W   (PN_W)
    ) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vpn  (req_addr[VA_W-1:OFF_W]),
        .lk_hit  (lk_hit),
        .lk_ppn  (lk_ppn),
        .ins_en  (ins_en),
        .ins_vpn (ins_vpn),
        .ins_ppn (ins_ppn),
        .flush   (kill)
    );

    ipa_xlate_walker #(
        .VA_W  (VA_W),
        .L1_W  (L1_W),
        .L2_W  (L2_W),
        .OFF_W (OFF_W)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .lk_hit        (lk_hit),
        .lk_ppn        (lk_ppn),
        .base_pn       (s_q.base_pn),
        .kill          (kill),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ins_en        (ins_en),
        .ins_vpn       (ins_vpn),
        .ins_ppn       (ins_ppn),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_addr      (rsp_addr)
    );

endmodule

// File: rtl/ipa_xlate_chk.sv
module ipa_xlate_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [VA_W-1:0] rsp_addr,
    input logic            mem_req_valid,
    input logic [VA_W-1:0] mem_req_addr
);
    // R12
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R12
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R12
    mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R5
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

    // R2
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

endmodule

bind ipa_xlate ipa_xlate_chk #(.VA_W(VA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_addr      (rsp_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/ipa_xlate_tb.sv
module ipa_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE0 = 32'h0001_0000;
    localparam logic [31:0] BASE1 = 32'h0003_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_ready, rsp_valid, rsp_fault;
    logic [31:0] req_addr, rsp_addr;
    logic        base_we, flush;
    logic [31:0] base_wdata;
    logic        mem_req_valid, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipa_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
        .base_we(base_we), .base_wdata(base_wdata), .flush(flush),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Table memory with a two-stage read pipeline
    logic [31:0] mem [int unsigned];
    logic        p1_v, p2_v;
    logic [31:0] p1_a, p2_d;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        p1_v <= rst_n && mem_req_valid;
        p1_a <= mem_req_addr;
        p2_v <= rst_n && p1_v;
        p2_d <= rd(p1_a);
    end
    assign mem_rsp_valid = p2_v;
    assign mem_rsp_data  = p2_d;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    chk_on = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model state
    bit          m_busy, m_hit, m_l1ok, m_ins, m_stale, m_fault;
    int          m_age, m_lat, m_ptr;
    logic [31:0] m_pa, m_l1a, m_l2a, m_va, m_base;
    logic [19:0] m_tag [4];
    logic [19:0] m_pg [4];
    bit          m_v [4];

    task automatic m_insert(input logic [19:0] t, input logic [19:0] p);
        int slot;
        slot = -1;
        for (int i = 3; i >= 0; i--) if (!m_v[i]) slot = i;
        if (slot < 0) begin
            slot  = m_ptr;
            m_ptr = (m_ptr + 1) % 4;
        end
        m_v[slot]   = 1'b1;
        m_tag[slot] = t;
        m_pg[slot]  = p;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_age = 0; m_lat = 0; m_ptr = 0; m_stale = 0;
            m_hit = 0; m_l1ok = 0; m_ins = 0; m_fault = 0; m_base = '0;
            for (int i = 0; i < 4; i++) m_v[i] = 0;
        end else begin
            bit          was_busy, hit_now;
            logic [19:0] hit_pg;
            logic [31:0] w1, w2;
            was_busy = m_busy;
            hit_now  = 0;
            hit_pg   = '0;
            for (int i = 0; i < 4; i++)
                if (m_v[i] && m_tag[i] == req_addr[31:12]) begin
                    hit_now = 1; hit_pg = m_pg[i];
                end
            if (m_busy) begin
                if (m_age == m_lat) m_busy = 0;
                else m_age++;
            end
            if (flush || base_we) begin
                for (int i = 0; i < 4; i++) m_v[i] = 0;
                if (was_busy) m_stale = 1;
            end
            if (base_we) m_base = {base_wdata[31:12], 12'h000};
            if (m_busy && m_age == m_lat && m_ins && !m_stale)
                m_insert(m_va[31:12], m_pa[31:12]);
            if (!was_busy && req_valid) begin
                m_va = req_addr; m_age = 1; m_busy = 1; m_stale = 0;
                m_ins = 0; m_fault = 0; m_l1ok = 0;
                if (hit_now) begin
                    m_hit = 1; m_lat = 1; m_pa = {hit_pg, req_addr[11:0]};
                end else begin
                    m_hit = 0;
                    m_l1a = {m_base[31:12], 12'h000} + {20'h0, req_addr[31:22], 2'b00};
                    w1 = rd(m_l1a);
                    if (!w1[0]) begin
                        m_lat = 4; m_fault = 1; m_pa = '0;
                    end else begin
                        m_l1ok = 1; m_lat = 7;
                        m_l2a = {w1[31:12], 12'h000} + {20'h0, req_addr[21:12], 2'b00};
                        w2 = rd(m_l2a);
                        if (!w2[0]) begin
                            m_fault = 1; m_pa = '0;
                        end else begin
                            m_pa = {w2[31:12], req_addr[11:0]}; m_ins = 1;
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            bit exp_rsp, exp_mq;
            exp_rsp = m_busy && (m_age == m_lat);
            exp_mq  = m_busy && !m_hit && ((m_age == 1) || (m_age == 4 && m_l1ok));
            chk("R12", 32'(req_ready), 32'(!m_busy), "req_ready");
            chk(cur_tag, 32'(rsp_valid), 32'(exp_rsp), "rsp_valid");
            if (exp_rsp) begin
                chk(cur_tag, 32'(rsp_fault), 32'(m_fault), "rsp_fault");
                chk(cur_tag, rsp_addr, m_pa, "rsp_addr");
            end
            chk("R12", 32'(mem_req_valid), 32'(exp_mq), "mem_req_valid");
            if (exp_mq) begin
                if (m_age == 1) chk("R2", mem_req_addr, m_l1a, "first-level read address");
                else            chk("R3", mem_req_addr, m_l2a, "second-level read address");
            end
        end
    end

    function automatic logic [31:0] va(input int i1, input int i2, input int off);
        return {10'(i1), 10'(i2), 12'(off)};
    endfunction

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    task automatic xlate(input logic [31:0] a, input string tag);
        wait_idle();
        cur_tag   = tag;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
    endtask

    task automatic write_base(input logic [31:0] b);
        wait_idle();
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic pulse_flush();
        wait_idle();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Guest 0 tables
        mem[BASE0 + 4]      = 32'h0002_0001;
        mem[BASE0 + 8]      = 32'h0002_0000;      // bit 0 clear: unusable
        for (int k = 3; k <= 9; k++)
            mem[32'h0002_0000 + 32'(4 * k)] = 32'h0A00_0001 | (32'(k) << 12);
        mem[32'h0002_0000 + 20] = 32'h0BAD_0000;  // second level, unusable
        // Guest 1 tables
        mem[BASE1 + 4]          = 32'h0004_0001;
        mem[32'h0004_0000 + 12] = 32'h0555_5001;

        req_valid = 0; req_addr = '0; base_we = 0; base_wdata = '0; flush = 0;
        repeat (3) @(negedge clk);
        chk("R1", 32'(req_ready), 32'(1), "req_ready in reset");
        chk("R1", 32'(rsp_valid), 32'(0), "rsp_valid in reset");
        chk("R1", 32'(mem_req_valid), 32'(0), "mem_req_valid in reset");
        rst_n  = 1'b1;
        chk_on = 1'b1;
        @(negedge clk);
        write_base(BASE0);

        xlate(va(1, 3, 12'h123), "R1");   // empty cache: walks
        xlate(va(1, 3, 12'hFFF), "R7");   // hit
        xlate(va(1, 9, 12'h010), "R4");
        xlate(va(2, 0, 12'h000), "R5");   // first-level unusable
        xlate(va(0, 1, 12'h000), "R5");   // first-level missing
        xlate(va(1, 5, 12'h044), "R6");
        xlate(va(1, 5, 12'h048), "R6");   // walks again

        pulse_flush();
        xlate(va(1, 3, 12'h001), "R10");  // walks after flush
        xlate(va(1, 4, 12'h002), "R8");
        xlate(va(1, 6, 12'h003), "R8");
        xlate(va(1, 7, 12'h004), "R8");   // cache now full
        xlate(va(1, 8, 12'h005), "R8");   // replaces slot 0
        xlate(va(1, 3, 12'h006), "R8");   // replaces slot 1
        xlate(va(1, 6, 12'h007), "R8");   // still cached
        xlate(va(1, 4, 12'h008), "R8");   // replaces slot 2
        xlate(va(1, 6, 12'h009), "R8");   // evicted: walks
        xlate(va(1, 8, 12'h00A), "R8");

        write_base(BASE1);
        xlate(va(1, 3, 12'h0AB), "R9");   // new guest tables
        xlate(va(1, 4, 12'h0AC), "R9");   // not mapped for this guest
        write_base(BASE0);
        xlate(va(1, 3, 12'h0AD), "R9");

        // Flush during a walk
        wait_idle();
        cur_tag = "R11"; req_valid = 1'b1; req_addr = va(1, 7, 12'h300);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        wait_idle();
        xlate(va(1, 7, 12'h301), "R11");  // not cached: walks again
        xlate(va(1, 7, 12'h302), "R11");  // now cached

        // Request held high across several services
        wait_idle();
        cur_tag = "R12"; req_valid = 1'b1; req_addr = va(1, 7, 12'h777);
        repeat (12) @(negedge clk);
        req_addr = va(2, 1, 12'h000);
        repeat (15) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule